// File: doc/BRIEF.md
# Framed Dual-Pattern Serial Detector

This block watches a serial bit stream that is cut into frames of four clock cycles. In the first three cycles of a frame it samples one data bit per rising edge. In the fourth cycle it reports the result and ignores the input. A Moore state machine keeps track of the bits taken so far. When the three bits of a frame, read in arrival order, are 0,1,1, the match flag for the first pattern is high during the result cycle. When they are 1,1,0, the flag for the second pattern is high instead. Any other frame leaves both flags low. Frames never overlap: the machine always starts a new frame after the result cycle. Sliding-window matching is not done.

An active-low asynchronous reset puts the machine in its idle state. The first bit sampled after reset is released is the first bit of a frame. A debug port shows the four-bit code of the current state. The machine uses a fixed state-code table in which neighbouring states mostly differ in a single bit. Both flags come straight from flip-flops, so they are free of decode glitches.

Top module: `frame_pattern_detector`

## Requirements
- R1: While rst_n is low, the state code is 4'b0000 and both flags are low. This takes effect without waiting for a clock edge.
- R2: After reset is released, the first rising edge samples bit one of a frame. Each frame takes exactly four rising edges: three sample data and the fourth ends the result cycle.
- R3: A frame received as 0 then 1 then 1 drives hit_a high for exactly the one result cycle. hit_b stays low.
- R4: A frame received as 1 then 1 then 0 drives hit_b high for exactly the one result cycle. hit_a stays low.
- R5: Any other three-bit frame keeps both flags low. In its result cycle the state code is 4'b1101.
- R6: The input bit present at the rising edge that ends the result cycle is ignored. The state code goes to 4'b0000 whatever its value.
- R7: The state codes seen on state_code follow a fixed table. Idle is 0000. After one bit the code is 0001 for a 0 and 0100 for a 1. After two bits it is 1001 for 00, 0011 for 01, 1100 for 10 and 0101 for 11. In the result cycle it is 0010 for the first pattern, 0111 for the second and 1101 for no match.
- R8: The flags are never high together. Each flag is high only while the state code is its own match code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sdin | input | 1 | Serial data bit, sampled on each rising edge |
| hit_a | output | 1 | Registered flag: the frame matched 0,1,1 |
| hit_b | output | 1 | Registered flag: the frame matched 1,1,0 |
| state_code | output | 4 | Current state code, for debug |

## Verification
First, directed frames drive all eight three-bit values. This tells the two matching frames apart from their six near misses, such as 0,1,0 and 1,1,1, that share a prefix with a pattern. Each of these frames is repeated with both values of the ignored fourth bit, which shows that the result cycle really discards its input. A long run of random frames then checks the flags and every intermediate state code against a bench model that counts position modulo four. Finally, a reset pulled in the middle of a frame shows that framing restarts at the first bit after release.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    ST_IDLE = 4'b0000,
    ST_B0   = 4'b0001,
    ST_B1   = 4'b0100,
    ST_B00  = 4'b1001,
    ST_B01  = 4'b0011,
    ST_B10  = 4'b1100,
    ST_B11  = 4'b0101,
    ST_MISS = 4'b1101,
    ST_HITA = 4'b0010,
    ST_HITB = 4'b0111
  } fpd_state_e;
endpackage

// File: rtl/fpd_next.sv
module fpd_next
  import fpd_pkg::*;
(
  input  fpd_state_e cur,
  input  logic       bit_in,
  output fpd_state_e nxt
);
  always_comb begin
    case (cur)
      ST_IDLE: nxt = bit_in ? ST_B1 : ST_B0;
      ST_B0:   nxt = bit_in ? ST_B01 : ST_B00;
      ST_B1:   nxt = bit_in ? ST_B11 : ST_B10;
      ST_B00:  nxt = ST_MISS;
      ST_B10:  nxt = ST_MISS;
      ST_B01:  nxt = bit_in ? ST_HITA : ST_MISS;
      ST_B11:  nxt = bit_in ? ST_MISS : ST_HITB;
      ST_MISS: nxt = ST_IDLE;
      ST_HITA: nxt = ST_IDLE;
      ST_HITB: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/fpd_state_reg.sv
module fpd_state_reg
  import fpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  fpd_state_e nxt,
  output fpd_state_e cur
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= ST_IDLE;
    else        cur <= nxt;
  end
endmodule

// File: rtl/fpd_flags.sv
module fpd_flags
  import fpd_pkg::*;
#(
  parameter int N_FLAGS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  fpd_state_e         nxt,
  output logic [N_FLAGS-1:0] flags
);
  localparam fpd_state_e HIT_CODES [2] = '{ST_HITA, ST_HITB};

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= 1'b0;
      else        flags[g] <= (nxt == HIT_CODES[g]);
    end
  end
endmodule

// File: rtl/frame_pattern_detector.sv
module frame_pattern_detector
  import fpd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdin,
  output logic              hit_a,
  output logic              hit_b,
  output logic [CODE_W-1:0] state_code
);
  fpd_state_e cur_st;
  fpd_state_e nxt_st;
  logic [1:0] flag_q;

  fpd_next u_next (
    .cur    (cur_st),
    .bit_in (sdin),
    .nxt    (nxt_st)
  );

  fpd_state_reg u_sreg (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt   (nxt_st),
    .cur   (cur_st)
  );

  fpd_flags #(.N_FLAGS(2)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt   (nxt_st),
    .flags (flag_q)
  );

  assign hit_a      = flag_q[0];
  assign hit_b      = flag_q[1];
  assign state_code = cur_st;
endmodule

// File: rtl/fpd_checker.sv
module fpd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       hit_a,
  input logic       hit_b,
  input logic [3:0] state_code
);
  // R1: state and flags are cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (state_code == 4'b0000 && !hit_a && !hit_b)
        else $error("reset state wrong");
    end
  end

  // R8
  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_a && hit_b));

  // R3
  p_hita_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |-> state_code == 4'b0010);

  // R4
  p_hitb_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b |-> state_code == 4'b0111);

  // R3
  p_hita_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |=> !hit_a);

  // R4
  p_hitb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b |=> !hit_b);

  // R6: every result cycle is followed by the idle state
  p_result_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'b0010 || state_code == 4'b0111 || state_code == 4'b1101)
      |=> state_code == 4'b0000);

  // R5
  p_miss_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_code == 4'b1101 |-> (!hit_a && !hit_b));
endmodule

bind frame_pattern_detector fpd_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit_a      (hit_a),
  .hit_b      (hit_b),
  .state_code (state_code)
);

// File: tb/sim_frame_pattern_detector.sv
module sim_frame_pattern_detector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sdin = 1'b0;
  logic       hit_a;
  logic       hit_b;
  logic [3:0] state_code;

  int total = 0;
  int bad = 0;
  int pos = 0;
  logic [2:0] hist = 3'b000;

  always #10 clk = ~clk;

  frame_pattern_detector u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .sdin       (sdin),
    .hit_a      (hit_a),
    .hit_b      (hit_b),
    .state_code (state_code)
  );

  // Expected state code after the bit at position p (0..3) of a frame.
  function automatic logic [3:0] exp_code(input int p, input logic [2:0] h);
    case (p)
      0: return h[0] ? 4'b0100 : 4'b0001;
      1: case ({h[0], h[1]})
           2'b00: return 4'b1001;
           2'b01: return 4'b0011;
           2'b10: return 4'b1100;
           default: return 4'b0101;
         endcase
      2: if (h == 3'b110) return 4'b0010;       // bits 0,1,1 (h[0] first)
         else if (h == 3'b011) return 4'b0111;  // bits 1,1,0
         else return 4'b1101;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one bit, let one rising edge pass, check at the falling edge.
  task automatic step(input logic b);
    logic [3:0] ec;
    logic ea, eb;
    string rq;
    sdin = b;
    @(posedge clk);
    @(negedge clk);
    if (pos < 3) hist[pos] = b;
    ec = exp_code(pos, hist);
    ea = (pos == 2) && (hist == 3'b110);
    eb = (pos == 2) && (hist == 3'b011);
    rq = (pos == 3) ? "R6" : (pos == 2 ? "R5/R7" : "R2/R7");
    check(rq, state_code, ec);
    check(ea ? "R3" : "R8", {3'b000, hit_a}, {3'b000, ea});
    check(eb ? "R4" : "R8", {3'b000, hit_b}, {3'b000, eb});
    pos = (pos + 1) % 4;
  endtask

  task automatic frame(input logic b0, input logic b1, input logic b2, input logic b3);
    step(b0); step(b1); step(b2); step(b3);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", {hit_b, hit_a, 2'b00}, 4'b0000);
    check("R1", state_code, 4'b0000);
    rst_n = 1'b1;
    pos = 0;
    // directed: all eight frames, each with both values of the ignored bit
    for (int v = 0; v < 8; v++) begin
      frame(v[2], v[1], v[0], 1'b0);
      frame(v[2], v[1], v[0], 1'b1);
    end
    // back-to-back matches
    frame(0, 1, 1, 1);
    frame(1, 1, 0, 0);
    frame(0, 1, 1, 0);
    // reset in mid-frame, asynchronous
    step(1'b0);
    step(1'b1);
    #3 rst_n = 1'b0;
    #2;
    check("R1", state_code, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    pos = 0;
    // first bit after release starts a frame
    frame(1, 1, 0, 1);
    // random frames
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      if (($urandom % 4) == 0) r[3:1] = ($urandom % 2) ? 3'b011 : 3'b110;
      frame(r[3], r[2], r[1], r[0]);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule